// File: doc/BRIEF.md
# Seven-bit serial transmitter with selectable parity

This block sends one 7-bit character at a time on a single serial line that sits at logic 1 when idle. Each character goes out as a ten-bit frame: a low start bit, the seven data bits with bit 0 first, a parity bit, and a high stop bit. The parity can be even or odd, chosen per character by one input.

A host starts a transfer with a level handshake. It drives the character, raises `send_i` and holds it. The block answers by raising `busy_o`. It captures the character and the parity choice, and it lowers `busy_o` once the stop bit has been fully sent. The host then lowers `send_i`. The block does not start another frame until it has seen `send_i` low.

An internal divider sets the bit time. It counts `CLK_HZ / BAUD` system clocks per bit and restarts at every frame load, so the first bit is never shortened. Inside the block are a bit-rate tick generator, a modulo-ten frame counter, a 9-bit frame register that shifts in ones from the top, and a control state machine.

Top module: `uart7_tx`

## Requirements
- R1: After reset `txd_o` is 1 and `busy_o` is 0.
- R2: When `send_i` is high in the idle state, `busy_o` is high from the next clock edge onward. `data_i` and `odd_par_i` are taken from the cycle in which `busy_o` first reads high.
- R3: The frame is a 0 start bit, then `data_i[0]` through `data_i[6]` in that order, then the parity bit, then a 1 stop bit.
- R4: The parity bit is the XOR of the seven data bits XORed with `odd_par_i`. A value of 0 selects even parity and a value of 1 selects odd parity.
- R5: Every bit of the frame holds on `txd_o` for exactly `CLK_HZ / BAUD` clock cycles. The start bit begins on the edge after `busy_o` rises.
- R6: `busy_o` stays high for `10 * CLK_HZ / BAUD + 1` cycles and falls on the edge that ends the stop bit.
- R7: While `busy_o` is low, `txd_o` is 1. After a frame, holding `send_i` high does not start a new frame. A new frame needs `send_i` to be seen low first.
- R8: Changes on `data_i` or `odd_par_i` after the capture cycle have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_i | input | 1 | Host transfer request, held high until busy falls |
| data_i | input | 7 | Character to send |
| odd_par_i | input | 1 | Parity choice: 0 even, 1 odd |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | High while a frame is in progress |

## Verification
The bench builds the block with `CLK_HZ = 4800` and `BAUD = 300`, which gives 16 clocks per bit and a 161-cycle busy window. At that size a full frame is short enough to sample every bit at its first and last cycle. That makes an off-by-one in the divider, the counter rollover or the busy timing show up as a wrong bit value at a bit edge. The characters are chosen so that neighbouring bits differ and both parity settings are used, and data is scrambled during each frame.

// File: rtl/uart7_tx_pkg.sv
package uart7_tx_pkg;
  // bit 1 of the encoding is the busy output
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DONE = 2'b01,
    ST_LOAD = 2'b10,
    ST_SEND = 2'b11
  } tx_state_e;
endpackage

// File: rtl/bit_tick_gen.sv
module bit_tick_gen #(
  parameter int unsigned CYC_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !clr_i;

  AST_TICK_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
  AST_TICK_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/frame_bit_ctr.sv
module frame_bit_ctr #(
  parameter int unsigned MOD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic wrap_o
);
  localparam int unsigned Q_W = $clog2(MOD);
  localparam logic [Q_W-1:0] TOP = Q_W'(MOD - 1);

  logic [Q_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (clr_i) q <= '0;
    else if (inc_i) q <= (q == TOP) ? '0 : q + 1'b1;
  end

  assign wrap_o = inc_i && (q == TOP);

  AST_CTR_ROLLOVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && q == TOP) |=> (q == '0)); // R6
  AST_CTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q <= TOP); // R6
endmodule

// File: rtl/frame_shreg.sv
module frame_shreg #(
  parameter int unsigned DATA_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic              ser_o
);
  localparam int unsigned REG_W = DATA_W + 2;

  logic [REG_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (load_i)  sr_q <= {par_i, data_i, 1'b0};
    else if (shift_i) sr_q <= {1'b1, sr_q[REG_W-1:1]};
  end

  assign ser_o = sr_q[0];

  AST_SR_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ser_o == 1'b0)); // R3
  AST_SR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(ser_o)); // R5
endmodule

// File: rtl/uart7_tx.sv
module uart7_tx
  import uart7_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_000_000,
  parameter int unsigned BAUD   = 300,
  parameter int unsigned DATA_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              odd_par_i,
  output logic              txd_o,
  output logic              busy_o
);
  localparam int unsigned CYC_PER_BIT = CLK_HZ / BAUD;
  localparam int unsigned FRAME_BITS  = DATA_W + 3;

  tx_state_e state_q, state_d;
  logic tick, wrap, load, shift, par;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (send_i) state_d = ST_LOAD;
      ST_LOAD: state_d = ST_SEND;
      ST_SEND: if (wrap) state_d = ST_DONE;
      ST_DONE: if (!send_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign load   = (state_q == ST_LOAD);
  assign shift  = (state_q == ST_SEND) && tick;
  assign par    = (^data_i) ^ odd_par_i;
  assign busy_o = state_q[1];

  bit_tick_gen #(.CYC_PER_BIT(CYC_PER_BIT)) i_tick (
    .clk_i, .rst_ni, .clr_i(load), .tick_o(tick)
  );

  frame_bit_ctr #(.MOD(FRAME_BITS)) i_ctr (
    .clk_i, .rst_ni, .clr_i(load), .inc_i(shift), .wrap_o(wrap)
  );

  frame_shreg #(.DATA_W(DATA_W)) i_sr (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift),
    .data_i, .par_i(par), .ser_o(txd_o)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o); // R7
  AST_BUSY_ON_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && send_i) |=> busy_o); // R2
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && send_i) |=> !busy_o); // R7
  AST_STOP_BEFORE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load && !state_d[1]) |-> txd_o); // R6
endmodule

// File: tb/test_uart7_tx.sv
module test_uart7_tx;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CLK_HZ = 4800;
  localparam int unsigned BAUD   = 300;
  localparam int unsigned CYC    = CLK_HZ / BAUD;

  logic clk = 0;
  logic rst_n = 0;
  logic send = 0;
  logic [6:0] data = '0;
  logic odd_par = 0;
  logic txd, busy;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart7_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(7)) i_uart7_tx (
    .clk_i(clk), .rst_ni(rst_n), .send_i(send), .data_i(data),
    .odd_par_i(odd_par), .txd_o(txd), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] make_frame(input logic [6:0] d, input logic odd);
    return {1'b1, (^d) ^ odd, d, 1'b0}; // bit 0 goes out first
  endfunction

  task automatic send_char(input logic [6:0] d, input logic odd);
    @(negedge clk);
    data = d; odd_par = odd; send = 1;
    exp_q.push_back(make_frame(d, odd));
    @(negedge clk);
    check(busy == 1'b1, "R2 busy response", busy, 1);
    @(negedge clk);
    data = ~d; odd_par = ~odd; // R8: scramble after capture
    while (busy) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check(busy == 1'b0, "R7 no restart while send held", busy, 0);
      check(txd == 1'b1, "R7 idle line high", txd, 1);
      @(negedge clk);
    end
    send = 0;
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    logic pb = 0;
    forever begin
      @(negedge clk);
      if (rst_n && busy && !pb) begin
        logic [9:0] f;
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected frame", 1, 0);
          f = '1;
        end else f = exp_q.pop_front();
        for (int n = 1; n <= 10 * CYC + 1; n++) begin
          @(negedge clk);
          for (int k = 0; k < 10; k++) begin
            if (n == 1 + k * CYC || n == (k + 1) * CYC) begin
              if (k == 8)
                check(txd == f[k], "R4 parity bit", txd, f[k]);
              else if (k == 0 || k == 9)
                check(txd == f[k], "R3 start/stop bit", txd, f[k]);
              else
                check(txd == f[k], "R5 R8 data bit timing", txd, f[k]);
            end
          end
          if (n == 10 * CYC)
            check(busy == 1'b1, "R6 busy held to stop end", busy, 1);
          if (n == 10 * CYC + 1) begin
            check(busy == 1'b0, "R6 busy falls after stop", busy, 0);
            check(txd == 1'b1, "R7 line idle after frame", txd, 1);
          end
        end
      end
      pb = busy;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1 reset txd", txd, 1);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(txd == 1'b1, "R1 idle txd after reset", txd, 1);
    send_char(7'h57, 1'b1);
    send_char(7'h57, 1'b0);
    send_char(7'h00, 1'b0);
    send_char(7'h00, 1'b1);
    send_char(7'h7F, 1'b1);
    send_char(7'h55, 1'b0);
    send_char(7'h2A, 1'b1);
    send_char(7'h01, 1'b0);
    send_char(7'h40, 1'b1);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule